// File: doc/BRIEF.md
# Asynchronous PSRAM Bus Controller

This block sits between on-chip logic and an external 512K x 16 pseudo-static RAM with an asynchronous interface. On-chip logic hands it one word at a time: an address, a read or write flag, write data and a two-bit lane mask. The controller turns each request into the pin sequence the memory expects. It drives the 19-bit address, two chip selects of opposite polarity, the write and output strobes and two lane strobes, and it owns a tri-state 16-bit data bus.

All analog timing limits are turned into wait-cycle counts when the design is elaborated. The inputs to that conversion are a clock-period parameter and a speed-grade parameter (55 or 70). Each count is the nanosecond limit divided by the clock period, rounded up, and never less than one cycle.

Each transfer runs through a fixed sequence: setup, access, end, recover. Reads are timed from chip select, and the address settles before chip select. Writes end on the strobe release, with the data held on the bus ahead of that release. The output strobe stays high for the whole of a write. Between transfers the memory is deselected and the bus is released.

Top module: `psram_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is high, the memory is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1, both lane strobes are high and `rsp_valid` is 0.
- R2: A request with `req_be`=0 is ignored. No chip select occurs, `req_ready` stays high, `rsp_valid` stays low and the stored contents do not change.
- R3: The address is on `mem_addr` for at least one cycle before chip select goes active, and it does not change while the memory is selected.
- R4: A read holds chip select active, `mem_oe_n` low and `mem_we_n` high for RD = ceil(max(select-access, output-enable-access, lane-access)/period) cycles. The select-access time is 55 ns or 70 ns by grade, and RD is at least 1.
- R5: A write holds chip select active, `mem_we_n` low and `mem_oe_n` high for WR cycles. WR is the larger of two values: ceil(largest write pulse or setup minimum/period), and ceil(write cycle time/period) minus 3. That gives at least 50 ns of pulse and 42 ns of data setup at grade 55. `mem_oe_n` is never low in the same cycle as `mem_we_n`.
- R6: The controller drives `mem_dq` only while a write is strobed and during the following end cycle. After a read it waits ceil(25 ns/period) recover cycles before a new transfer can start, so the memory's output release never overlaps a write.
- R7: `req_be[0]` selects the low lane (`mem_lb_n` low, `mem_dq[7:0]`) and `req_be[1]` selects the high lane (`mem_ub_n` low, `mem_dq[15:8]`). A write changes only the enabled lanes.
- R8: For a read accepted at clock edge 1 (the edge where `req_valid` and `req_ready` are both high), `rsp_valid` is high for exactly one cycle after edge RD+3. `rsp_rdata` then holds the enabled lanes and zero in the lanes that were not enabled.
- R9: For a write accepted at edge 1, `rsp_valid` is high for one cycle after edge WR+3.
- R10: `req_ready` goes high again after edge RD+3+ceil(25 ns/period) for a read, and after edge WR+4 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| req_ready | output | 1 | Controller idle; request taken when valid and ready |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lb_n | output | 1 | Low lane strobe, active low |
| mem_ub_n | output | 1 | High lane strobe, active low |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The bench builds the controller at grade 55 with a 4 ns period. That gives 14 read-access cycles, 13 write-access cycles and 7 read-recover cycles, all long enough to observe edge by edge. The bench's memory model holds only 16 words, indexed by the low address bits. This lets the bench sweep every word with every nonempty lane mask for both writes and reads. The model times each strobe in cycles, checks pulse width, data setup, address stability and bus overlap against the grade's limits, and drives garbage until the access time has passed.

// File: rtl/psram_ctrl_pkg.sv
`timescale 1ns/1ps
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    PC_IDLE    = 3'd0,
    PC_SETUP   = 3'd1,
    PC_ACCESS  = 3'd2,
    PC_END     = 3'd3,
    PC_RECOVER = 3'd4
  } pc_state_e;

  // Cycles covering a nanosecond limit, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned r;
    r = (ns + per - 1) / per;
    if (r < 1) r = 1;
    return r;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_wait_cnt.sv
`timescale 1ns/1ps
module psram_wait_cnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             last,
  output logic             first
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last  = (cnt_q == limit - 1'b1);
  assign first = (cnt_q == '0);
endmodule

// File: rtl/psram_fsm.sv
`timescale 1ns/1ps
module psram_fsm
  import psram_ctrl_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic [CNT_W-1:0] rd_cyc,
  input  logic [CNT_W-1:0] wr_cyc,
  input  logic [CNT_W-1:0] rec_cyc,
  output pc_state_e        state,
  output logic             wr_q,
  output logic             accept,
  output logic             cap_en,
  output logic             rsp_valid
);
  pc_state_e        state_q, state_d;
  logic             wr_d;
  logic [CNT_W-1:0] limit;
  logic             last, first, cnt_clr, cnt_en;

  // A request with no lane enabled never leaves idle.
  assign accept = (state_q == PC_IDLE) && req_valid && (|req_be);

  always_comb begin
    case (state_q)
      PC_ACCESS:  limit = wr_q ? wr_cyc : rd_cyc;
      PC_RECOVER: limit = wr_q ? CNT_W'(1) : rec_cyc;
      default:    limit = CNT_W'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      PC_IDLE:    if (accept) state_d = PC_SETUP;
      PC_SETUP:   state_d = PC_ACCESS;
      PC_ACCESS:  if (last) state_d = PC_END;
      PC_END:     state_d = PC_RECOVER;
      PC_RECOVER: if (last) state_d = PC_IDLE;
      default:    state_d = PC_IDLE;
    endcase
  end

  assign wr_d    = accept ? req_write : wr_q;
  assign cnt_clr = (state_d != state_q);
  assign cnt_en  = (state_q == PC_ACCESS) || (state_q == PC_RECOVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PC_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= wr_d;
    end
  end

  psram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .limit (limit),
    .last  (last),
    .first (first)
  );

  assign state     = state_q;
  assign cap_en    = (state_q == PC_ACCESS) && last && !wr_q;
  assign rsp_valid = (state_q == PC_RECOVER) && first;
endmodule

// File: rtl/psram_datapath.sv
`timescale 1ns/1ps
module psram_datapath
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_state_e         state,
  input  logic              wr_q,
  input  logic              accept,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive,
  output logic              ce1_n,
  output logic              ce2,
  output logic              we_n,
  output logic              oe_n,
  output logic [LANES-1:0]  lane_n,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] lane_mask;
  logic              sel, lanes_on;

  // Request fields are held from acceptance until the next acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  assign sel      = (state == PC_ACCESS);
  assign lanes_on = (state == PC_SETUP) || sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{be_q[g]}};
    assign lane_n[g] = !(lanes_on && be_q[g]);
  end

  assign rdata_d = cap_en ? (dq_in & lane_mask) : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign mem_addr = addr_q;
  assign ce1_n    = !sel;
  assign ce2      = sel;
  assign we_n     = !(sel && wr_q);
  assign oe_n     = !(sel && !wr_q);
  assign dq_drive = wr_q && (sel || (state == PC_END));
  assign dq_out   = wdata_q;
  assign rdata    = rdata_q;
endmodule

// File: rtl/psram_ctrl.sv
`timescale 1ns/1ps
module psram_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 4,
  parameter int SPEED_GRADE   = 55,
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int LANES = 2;
  localparam int unsigned PER  = CLK_PERIOD_NS;
  localparam bit          FAST = (SPEED_GRADE == 55);

  // Read limits (ns)
  localparam int unsigned T_SEL_ACC = FAST ? 55 : 70;
  localparam int unsigned T_OE_ACC  = FAST ? 25 : 35;
  localparam int unsigned T_LN_ACC  = FAST ? 25 : 35;
  localparam int unsigned T_REL     = 25;
  // Write minimums (ns)
  localparam int unsigned T_W_SEL   = FAST ? 45 : 55;
  localparam int unsigned T_W_ADDR  = FAST ? 45 : 55;
  localparam int unsigned T_W_PULSE = FAST ? 40 : 55;
  localparam int unsigned T_W_LANE  = FAST ? 50 : 55;
  localparam int unsigned T_W_DATA  = 42;
  localparam int unsigned T_W_CYC   = FAST ? 55 : 70;

  localparam int unsigned RD_NS  = umax(T_SEL_ACC, umax(T_OE_ACC, T_LN_ACC));
  localparam int unsigned WR_NS  = umax(umax(T_W_SEL, T_W_ADDR),
                                        umax(T_W_PULSE, umax(T_W_LANE, T_W_DATA)));
  localparam int unsigned WC_CYC = ns_to_cyc(T_W_CYC, PER);
  localparam int unsigned RD_CYC = ns_to_cyc(RD_NS, PER);
  localparam int unsigned WR_CYC = umax(ns_to_cyc(WR_NS, PER), (WC_CYC > 4) ? WC_CYC - 3 : 1);
  localparam int unsigned RC_CYC = ns_to_cyc(T_REL, PER);
  localparam int unsigned MX_CYC = umax(RD_CYC, umax(WR_CYC, RC_CYC));
  localparam int CNT_W = $clog2(MX_CYC + 1);

  pc_state_e         state;
  logic              wr_q, accept, cap_en, dq_drive;
  logic [DATA_W-1:0] dq_out;
  logic [LANES-1:0]  lane_n;

  psram_fsm #(.CNT_W(CNT_W), .LANES(LANES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .rd_cyc    (CNT_W'(RD_CYC)),
    .wr_cyc    (CNT_W'(WR_CYC)),
    .rec_cyc   (CNT_W'(RC_CYC)),
    .state     (state),
    .wr_q      (wr_q),
    .accept    (accept),
    .cap_en    (cap_en),
    .rsp_valid (rsp_valid)
  );

  psram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .wr_q      (wr_q),
    .accept    (accept),
    .cap_en    (cap_en),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .dq_in     (mem_dq),
    .mem_addr  (mem_addr),
    .dq_out    (dq_out),
    .dq_drive  (dq_drive),
    .ce1_n     (mem_ce1_n),
    .ce2       (mem_ce2),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .lane_n    (lane_n),
    .rdata     (rsp_rdata)
  );

  assign mem_lb_n  = lane_n[0];
  assign mem_ub_n  = lane_n[LANES-1];
  assign req_ready = (state == PC_IDLE);
  assign mem_dq    = dq_drive ? dq_out : {DATA_W{1'bz}};
endmodule

// File: rtl/psram_ctrl_chk.sv
`timescale 1ns/1ps
module psram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic              dq_drive
);
  logic selected;
  assign selected = !mem_ce1_n && mem_ce2;

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n)); // R1
  AST_NO_EMPTY_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> !(mem_lb_n && mem_ub_n)); // R2
  AST_ADDR_BEFORE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected) |-> $stable(mem_addr)); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && $past(selected)) |-> $stable(mem_addr)); // R3
  AST_STROBES_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && $past(selected)) |-> ($stable(mem_we_n) && $stable(mem_oe_n)
                                       && $stable(mem_lb_n) && $stable(mem_ub_n))); // R4
  AST_WRITE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (selected && mem_oe_n)); // R5
  AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> mem_oe_n); // R6
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !dq_drive); // R6
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
endmodule

bind psram_ctrl psram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_lb_n  (mem_lb_n),
  .mem_ub_n  (mem_ub_n),
  .dq_drive  (dq_drive)
);

// File: tb/psram_ctrl_test.sv
`timescale 1ns/1ps
module psram_ctrl_test;
  localparam int PER = 4;
  localparam int GRADE = 55;

  function automatic int cdiv(input int ns);
    int r;
    r = (ns + PER - 1) / PER;
    return (r < 1) ? 1 : r;
  endfunction

  // Expected counts at grade 55, derived from the requirement formulas.
  localparam int E_RD  = cdiv(55);
  localparam int E_WR  = (cdiv(50) > cdiv(55) - 3) ? cdiv(50) : cdiv(55) - 3;
  localparam int E_REC = cdiv(25);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  wire  [15:0] mem_dq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  psram_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(GRADE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_dq(mem_dq)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory model (16 words) ----------------
  logic [15:0] mdl [16];
  logic        m_drv = 1'b0;
  logic [15:0] m_word = '0;
  logic        m_sel_p = 0, m_wr_p = 0, m_rd_p = 0, m_lb_p = 1, m_ub_p = 1;
  logic [18:0] m_addr_p = '0;
  logic [15:0] m_dq_p = '0;
  int m_wr_len = 0, m_dsu = 0, m_rd_len = 0, m_hz = 0;
  int last_rd_len = 0, last_wr_len = 0;

  assign mem_dq = m_drv ? m_word : 16'hzzzz;

  always @(posedge clk) begin
    logic sel, wr_act, rd_en;
    #1;
    sel    = !mem_ce1_n && mem_ce2;
    wr_act = sel && !mem_we_n && !(mem_lb_n && mem_ub_n);
    rd_en  = sel && !mem_oe_n && mem_we_n;
    if (!rst_n) begin
      m_wr_len = 0; m_rd_len = 0; m_hz = 0; m_drv = 0;
      m_sel_p = 0; m_wr_p = 0; m_rd_p = 0;
    end else begin
      if (!mem_oe_n && !mem_we_n) chk(0, "R5", "oe and we both low", 0, 1);
      if (sel && mem_addr != m_addr_p)
        chk(0, "R3", "address moved at or during select", int'(mem_addr), int'(m_addr_p));
      if (wr_act) begin
        m_wr_len++;
        if (!m_wr_p || mem_dq !== m_dq_p) m_dsu = 1; else m_dsu++;
      end
      if (m_wr_p && !wr_act) begin
        chk(m_wr_len * PER >= 50, "R5", "write pulse ns", m_wr_len * PER, 50);
        chk(m_dsu * PER >= 42, "R5", "data setup ns", m_dsu * PER, 42);
        if (!m_lb_p) mdl[m_addr_p[3:0]][7:0]  = m_dq_p[7:0];
        if (!m_ub_p) mdl[m_addr_p[3:0]][15:8] = m_dq_p[15:8];
        last_wr_len = m_wr_len;
        m_wr_len = 0;
      end
      if (m_hz > 0 && !mem_we_n) chk(0, "R6", "write overlaps read release", m_hz, 0);
      if (rd_en) m_rd_len++;
      if (m_rd_p && !rd_en) begin
        last_rd_len = m_rd_len; m_rd_len = 0; m_hz = E_REC;
      end else if (m_hz > 0) m_hz--;
      m_drv = rd_en;
      if (rd_en && m_rd_len * PER >= 55) begin
        m_word[7:0]  = mem_lb_n ? 8'hA5 : mdl[mem_addr[3:0]][7:0];
        m_word[15:8] = mem_ub_n ? 8'h5A : mdl[mem_addr[3:0]][15:8];
      end else m_word = 16'hDEAD;
      m_sel_p = sel; m_wr_p = wr_act; m_rd_p = rd_en;
      m_lb_p = mem_lb_n; m_ub_p = mem_ub_n; m_dq_p = mem_dq;
    end
    m_addr_p = mem_addr;
  end

  // ---------------- stimulus ----------------
  logic [15:0] shadow [16];

  task automatic do_op(input logic wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] be, output logic [15:0] rd,
                       output int lat_rsp, output int lat_rdy);
    int edges;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk); edges = 1;
    @(negedge clk); req_valid = 0;
    lat_rsp = -1; lat_rdy = -1; rd = '0;
    while (edges < 2000) begin
      if (rsp_valid && lat_rsp < 0) begin lat_rsp = edges; rd = rsp_rdata; end
      if (req_ready) begin lat_rdy = edges; break; end
      @(posedge clk); edges++;
      @(negedge clk);
    end
  endtask

  function automatic logic [18:0] addr_of(input int i);
    return {15'(i * 977 + 3), 4'(i)};
  endfunction

  function automatic logic [15:0] mask_of(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  initial begin
    logic [15:0] rd, exp;
    int lr, ly;
    for (int i = 0; i < 16; i++) begin mdl[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    chk({mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} === 6'b101111,
        "R1", "pins in reset", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 6'b101111);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1", "idle after reset",
        {rsp_valid, req_ready}, 2'b01);

    // Writes: every word, full then each single lane (R5, R7, R9, R10)
    for (int i = 0; i < 16; i++) begin
      for (int m = 3; m >= 1; m--) begin
        logic [15:0] d;
        d = 16'(i * 16'h1357 + m * 16'h2461);
        do_op(1, addr_of(i), d, 2'(m), rd, lr, ly);
        shadow[i] = (shadow[i] & ~mask_of(2'(m))) | (d & mask_of(2'(m)));
        chk(lr == E_WR + 3, "R9", "write rsp latency", lr, E_WR + 3);
        chk(ly == E_WR + 4, "R10", "write ready return", ly, E_WR + 4);
        chk(last_wr_len == E_WR, "R5", "write strobe cycles", last_wr_len, E_WR);
      end
    end

    // R2: empty mask for several cycles
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = addr_of(5); req_wdata = 16'hFFFF; req_be = 2'b00;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(mem_ce1_n === 1'b1 && req_ready === 1'b1 && rsp_valid === 1'b0, "R2",
          "empty mask ignored", {mem_ce1_n, req_ready, rsp_valid}, 3'b110);
    end
    req_valid = 0;

    // Reads: every word, each lane mask (R4, R6, R7, R8, R10)
    for (int i = 0; i < 16; i++) begin
      for (int m = 1; m <= 3; m++) begin
        do_op(0, addr_of(i), 16'h0, 2'(m), rd, lr, ly);
        exp = shadow[i] & mask_of(2'(m));
        chk(rd === exp, "R8", "read data (R7 lanes)", int'(rd), int'(exp));
        chk(lr == E_RD + 3, "R8", "read rsp latency", lr, E_RD + 3);
        chk(ly == E_RD + 3 + E_REC, "R10", "read ready return (R6)", ly, E_RD + 3 + E_REC);
        chk(last_rd_len == E_RD, "R4", "read strobe cycles", last_rd_len, E_RD);
      end
    end

    // Back-to-back read then write then read of the same word (R6)
    do_op(0, addr_of(2), 16'h0, 2'b11, rd, lr, ly);
    do_op(1, addr_of(2), 16'hC3E1, 2'b11, rd, lr, ly);
    do_op(0, addr_of(2), 16'h0, 2'b11, rd, lr, ly);
    chk(rd === 16'hC3E1, "R6", "turnaround readback", int'(rd), 16'hC3E1);
    // R2: word 5 untouched by the empty-mask request
    do_op(0, addr_of(5), 16'h0, 2'b11, rd, lr, ly);
    chk(rd === shadow[5], "R2", "word unchanged", int'(rd), int'(shadow[5]));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * PER);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule